// File: doc/BRIEF.md
# Dual-Edge Interleaved Burst Capture

This block records a fixed-length burst from a sample bus using both edges of a single clock, which doubles the capture rate without a faster clock. Two capture paths work side by side. One stores a value on every rising edge and the other on every falling edge. Each path has its own counter, its own status bits and its own storage array, and no register is written from both edges. The only things the paths share are the reset and a launch pulse.

A read port presents the two arrays as one buffer in time order. Even buffer positions come from the rising path and odd positions from the falling path. Reading position i therefore returns the i-th value the block saw after the burst began. A start request is accepted on a rising edge when the block is idle or finished. The done flag rises once both paths hold their full share, and the buffer is meant to be read only after that.

Top module: `dual_edge_capture`

## Requirements
- R1: When `start` is high at rising edge k and the block is idle or done, the rising path stores `din` at rising edges k+1 through k+DEPTH, one value per edge. With the defaults, DEPTH is 100.
- R2: The falling path stores `din` at the DEPTH falling edges that follow rising edges k+1 through k+DEPTH. Its first capture is at the falling edge just after rising edge k+1.
- R3: `rd_data` is combinational in `rd_idx`. An even index 2n returns rising sample n, and an odd index 2n+1 returns falling sample n. Buffer entry i is therefore the value present at the i-th capture edge, counted in time order.
- R4: `done` is low through the falling edge after rising edge k+DEPTH and goes high at rising edge k+DEPTH+1.
- R5: `done` stays high until a new start is accepted. It goes low at the accepting rising edge, and the next burst overwrites the whole buffer.
- R6: A `start` that is high at any rising edge while a burst is running is ignored. This includes the edges at which the burst completes. The buffer contents and the timing of `done` are unchanged.
- R7: Once `done` is high, changes on `din` leave every buffer entry unchanged.
- R8: Driving `rst_n` low immediately forces `done` low and clears both paths' counters and status. A `start` given while reset is low is not acted on. After release the block stays idle, with `done` low, until a new start is accepted.
- R9: A `rd_idx` of 2*DEPTH or more returns zero on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Burst request, sampled on rising edges |
| din | input | DATA_W (8) | Sample bus |
| rd_idx | input | $clog2(2*DEPTH) (8) | Index into the combined buffer |
| rd_data | output | DATA_W (8) | Combined buffer entry at `rd_idx` |
| done | output | 1 | High once both paths have filled |

## Verification
Two events can meet on the same rising edge: a fresh start request, and the control stage seeing both paths full and declaring the burst finished. The bench holds `start` high across rising edges k+DEPTH and k+DEPTH+1. It expects `done` to rise at k+DEPTH+1 and to remain high one cycle later, so the coinciding request must neither restart the burst nor delay completion. It then checks every buffer entry against the arithmetic pattern it drove.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

    // Which clock edge a capture path stores on.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    // Burst control state, registered on the rising edge.
    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_BUSY = 2'd1,
        RUN_DONE = 2'd2
    } run_state_e;

    typedef struct packed {
        run_state_e st;
        logic       launch;
    } ctrl_t;

endpackage

// File: rtl/dcap_edge_path.sv
module dcap_edge_path
    import dcap_pkg::*;
#(
    parameter int        DEPTH  = 100,
    parameter int        DATA_W = 8,
    parameter edge_sel_e EDGE   = EDGE_RISE,
    localparam int       CNT_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] din,
    input  logic [CNT_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             busy;
        logic             full;
    } path_t;

    path_t             path_d, path_q;
    logic              mem_we;
    logic [CNT_W-1:0]  mem_wa;
    logic [DATA_W-1:0] mem [DEPTH];

    // Next-state: the falling path inserts one arm stage so that its first
    // capture lands after the rising path's first capture.
    always_comb begin
        path_d = path_q;
        mem_we = 1'b0;
        mem_wa = path_q.cnt;
        if (launch && !path_q.busy && !path_q.armed) begin
            path_d.full = 1'b0;
            path_d.cnt  = '0;
            if (EDGE == EDGE_FALL) begin
                path_d.armed = 1'b1;
            end else begin
                mem_we      = 1'b1;
                mem_wa      = '0;
                path_d.busy = 1'b1;
                path_d.cnt  = ONE;
            end
        end else if (path_q.armed) begin
            path_d.armed = 1'b0;
            path_d.busy  = 1'b1;
            mem_we       = 1'b1;
            mem_wa       = '0;
            path_d.cnt   = ONE;
        end else if (path_q.busy) begin
            mem_we = 1'b1;
            mem_wa = path_q.cnt;
            if (path_q.cnt == LAST) begin
                path_d.busy = 1'b0;
                path_d.full = 1'b1;
                path_d.cnt  = '0;
            end else begin
                path_d.cnt = path_q.cnt + ONE;
            end
        end
    end

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) path_q <= '0;
                else        path_q <= path_d;
            end
            always_ff @(posedge clk) begin
                if (rst_n && mem_we) mem[mem_wa] <= din;
            end
        end else begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) path_q <= '0;
                else        path_q <= path_d;
            end
            always_ff @(negedge clk) begin
                if (rst_n && mem_we) mem[mem_wa] <= din;
            end
        end
    endgenerate

    assign rd_data = ({1'b0, rd_addr} < (CNT_W+1)'(DEPTH)) ? mem[rd_addr] : '0;
    assign full    = path_q.full;

endmodule

// File: rtl/dcap_merge_read.sv
module dcap_merge_read #(
    parameter int  DEPTH  = 100,
    parameter int  DATA_W = 8,
    localparam int IDX_W  = $clog2(2 * DEPTH),
    localparam int CNT_W  = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  slot,
    input  logic [DATA_W-1:0] rise_data,
    input  logic [DATA_W-1:0] fall_data,
    output logic [DATA_W-1:0] rd_data
);

    logic in_range;

    // Index bit 0 picks the edge; the remaining bits pick the slot.
    assign slot     = rd_idx[IDX_W-1:1];
    assign in_range = {1'b0, rd_idx} < (IDX_W+1)'(2 * DEPTH);

    always_comb begin
        if (!in_range)      rd_data = '0;
        else if (rd_idx[0]) rd_data = fall_data;
        else                rd_data = rise_data;
    end

endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
    import dcap_pkg::*;
#(
    parameter int  DEPTH  = 100,
    parameter int  DATA_W = 8,
    localparam int IDX_W  = $clog2(2 * DEPTH),
    localparam int CNT_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    ctrl_t             ctrl_d, ctrl_q;
    logic              rise_full, fall_full;
    logic              launch;
    logic [CNT_W-1:0]  slot;
    logic [DATA_W-1:0] rise_data, fall_data;

    // Control: accept a start only when idle or finished; finish once both
    // paths report full.
    always_comb begin
        ctrl_d        = ctrl_q;
        ctrl_d.launch = 1'b0;
        case (ctrl_q.st)
            RUN_IDLE, RUN_DONE: begin
                if (start) begin
                    ctrl_d.st     = RUN_BUSY;
                    ctrl_d.launch = 1'b1;
                end
            end
            RUN_BUSY: begin
                if (rise_full && fall_full) ctrl_d.st = RUN_DONE;
            end
            default: ctrl_d.st = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{st: RUN_IDLE, launch: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign launch = ctrl_q.launch;
    assign done   = (ctrl_q.st == RUN_DONE);

    dcap_edge_path #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .EDGE  (EDGE_RISE)
    ) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .din    (din),
        .rd_addr(slot),
        .rd_data(rise_data),
        .full   (rise_full)
    );

    dcap_edge_path #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .EDGE  (EDGE_FALL)
    ) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .din    (din),
        .rd_addr(slot),
        .rd_data(fall_data),
        .full   (fall_full)
    );

    dcap_merge_read #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_merge (
        .rd_idx   (rd_idx),
        .slot     (slot),
        .rise_data(rise_data),
        .fall_data(fall_data),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
    parameter int  DEPTH  = 100,
    parameter int  DATA_W = 8,
    localparam int IDX_W  = $clog2(2 * DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              launch,
    input logic              rise_full,
    input logic              fall_full,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_data
);

    // R4
    done_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rise_full && fall_full));

    // R5
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R6
    launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    // R5
    launch_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !done);

    // R2
    fall_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_full) |-> rise_full);

    // R9
    oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_idx} >= (IDX_W+1)'(2 * DEPTH)) |-> (rd_data == '0));

endmodule

bind dual_edge_capture dual_edge_capture_chk #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .launch   (launch),
    .rise_full(rise_full),
    .fall_full(fall_full),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
);

// File: tb/dual_edge_capture_tb.sv
module dual_edge_capture_tb;

    localparam int DEPTH  = 100;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(2 * DEPTH);
    localparam int TOTAL  = 2 * DEPTH;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [DATA_W-1:0] din;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              done;

    int n_checks = 0;
    int n_fails  = 0;

    dual_edge_capture #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .din    (din),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .done   (done)
    );

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] pat(int p, int h);
        case (p)
            0:       return DATA_W'(h);
            1:       return DATA_W'(255 - h);
            2:       return DATA_W'((h * 37 + 11) % 256);
            default: return (h % 2 == 1) ? DATA_W'(8'hA5 ^ h) : DATA_W'(8'h5A + h);
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // mode 0: plain burst; mode 1: extra start mid-burst; mode 2: start held
    // across the completing edges.
    task automatic run_burst(int p, int mode, bit was_done);
        @(posedge clk); #2;
        start = 1'b1;
        din   = 8'hEE;
        @(posedge clk); #2;              // edge k accepted the start
        start = 1'b0;
        check(was_done ? "R5 done clears" : "R1 accept", done, 0);
        for (int h = 0; h < TOTAL; h++) begin
            @(clk); #2;
            din = pat(p, h);
            if (mode == 1 && h == 81)  start = 1'b1;
            if (mode == 1 && h == 83)  start = 1'b0;
            if (mode == 2 && h == 197) start = 1'b1;
        end
        @(clk); #2;                      // falling edge after k+DEPTH
        check("R4 done low before finish", done, 0);
        @(posedge clk); #2;              // edge k+DEPTH+1
        check("R4 done at finish", done, 1);
        start = 1'b0;
        @(posedge clk); #2;
        check(mode == 2 ? "R6 start at finish ignored" : "R5 done holds", done, 1);
        for (int j = 0; j < 20; j++) begin
            @(clk); #2;
            din = DATA_W'(j * 53 + 7);
        end
        check("R7 done steady", done, 1);
        for (int i = 0; i < TOTAL; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            if (mode == 1)
                check("R6 buffer intact", rd_data, pat(p, i));
            else if (i % 2 == 0)
                check("R1 R3 R7 rising entry", rd_data, pat(p, i));
            else
                check("R2 R3 R7 falling entry", rd_data, pat(p, i));
        end
    endtask

    initial begin
        rst_n  = 1'b0;
        start  = 1'b0;
        din    = '0;
        rd_idx = IDX_W'(250);
        #20;
        check("R8 reset done", done, 0);
        check("R9 reset oob", rd_data, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        run_burst(0, 0, 1'b0);
        run_burst(1, 1, 1'b1);
        run_burst(2, 2, 1'b1);

        // Reset in the middle of a burst, with a start given during reset.
        @(posedge clk); #2;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (20) @(posedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        check("R8 async clear", done, 0);
        start = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        start = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1;
        repeat (2 * DEPTH + 30) @(posedge clk);
        #2;
        check("R8 idle after reset", done, 0);

        run_burst(3, 0, 1'b0);
        for (int i = TOTAL; i < (1 << IDX_W); i++) begin
            rd_idx = IDX_W'(i);
            #1;
            check("R9 out of range", rd_data, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule